// File: doc/BRIEF.md
# Display RAM Auto-Increment Address Generator

This block holds the column (X) and row (Y) address that a processor uses to reach the display memory of a dot-matrix LCD controller. Software loads both coordinates at once through one 8-bit write-only register. After that, each qualifying display-memory access moves the address forward automatically, so a run of accesses walks the visible area without any reload.

One axis counts fastest and the other takes its carry. A mode bit picks which axis is the fast one. The last valid coordinate on each axis depends on the duty setting and on a segment-option flag. When the fast axis passes its last valid value, it returns to 0 and the slow axis advances. A second mode bit picks which access direction counts as qualifying. This lets a read-then-write pair stay on the same cell.

Top module: `lcd_addr_gen`

## Requirements
- R1: While reset is applied, and on the first cycle after it is released, X and Y are both 0.
- R2: A register write loads X from data bits 7:5 and Y from data bits 4:0. The new values appear on the outputs on the cycle after the write.
- R3: A register write in the same cycle as a qualifying access wins. The register value is loaded and there is no increment.
- R4: With rmw_mode=0, only an access with acc_write=1 qualifies. With rmw_mode=1, only an access with acc_write=0 qualifies. In a cycle with no qualifying access and no register write, X and Y hold.
- R5: With inc_x=1, a qualifying access while X is below its last valid value adds 1 to X and leaves Y unchanged.
- R6: With inc_x=1, a qualifying access while X is at its last valid value sets X to 0. Y also advances by 1, or goes to 0 if Y was already at its last valid value.
- R7: With inc_x=0, a qualifying access while Y is below its last valid value adds 1 to Y and leaves X unchanged.
- R8: With inc_x=0, a qualifying access while Y is at its last valid value sets Y to 0. X also advances by 1, or goes to 0 if X was already at its last valid value.
- R9: The last valid Y depends on duty. duty=2'b00 (1/8) gives 7, duty=2'b01 (1/16) gives 15, and duty=2'b10 or 2'b11 (1/32) gives 31.
- R10: With seg_opt=0, the last valid X is 7. With seg_opt=1, it is 6 at 1/16 duty, 4 at 1/32 duty and 7 at 1/8 duty.
- R11: A coordinate loaded above its last valid value is treated as being at that value. On its axis it wraps to 0 on the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Address register write strobe |
| reg_wdata | input | 8 | Register data: X in bits 7:5, Y in bits 4:0 |
| acc_valid | input | 1 | Display memory access strobe |
| acc_write | input | 1 | Access direction: 1 write, 0 read |
| inc_x | input | 1 | 1: X is the fast axis; 0: Y is the fast axis |
| rmw_mode | input | 1 | 0: writes advance the address; 1: reads advance it |
| duty | input | 2 | 00 1/8, 01 1/16, 1x 1/32 |
| seg_opt | input | 1 | Segment option, narrows the X range |
| x_addr | output | 3 | Current X address |
| y_addr | output | 5 | Current Y address |

## Verification
The bench targets the double carry, where both axes sit at their limit and must both return to 0. A design that is wrong here leaves the slow axis stuck at 8 or 16, or lets it overflow. Every duty and segment-option pairing is visited, so a limit table that is off by one shows up as an early wrap or a late wrap. Addresses loaded above the limit check the wrap rule; an equality compare would let them count on to the top of the field. The bench also checks that a register write beats a simultaneous access, and that the access direction chosen by rmw_mode is the only one that moves the address. A design that lets the increment win drifts away from the value just loaded.

// File: rtl/lcd_addr_pkg.sv
package lcd_addr_pkg;
  localparam int unsigned XW = 3;
  localparam int unsigned YW = 5;
  localparam int unsigned RW = XW + YW;

  typedef enum logic [1:0] {
    DUTY_8  = 2'b00,
    DUTY_16 = 2'b01,
    DUTY_32 = 2'b10,
    DUTY_32B = 2'b11
  } duty_e;
endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lcd_addr_limits.sv
module lcd_addr_limits
  import lcd_addr_pkg::*;
(
  input  logic          clk,
  input  logic          srst_n,
  input  logic [1:0]    duty,
  input  logic          seg_opt,
  output logic [XW-1:0] max_x,
  output logic [YW-1:0] max_y
);
  always_comb begin
    unique case (duty_e'(duty))
      DUTY_8:  max_y = YW'(7);
      DUTY_16: max_y = YW'(15);
      default: max_y = YW'(31);
    endcase
  end

  always_comb begin
    max_x = XW'(7);
    if (seg_opt) begin
      unique case (duty_e'(duty))
        DUTY_8:  max_x = XW'(7);
        DUTY_16: max_x = XW'(6);
        default: max_x = XW'(4);
      endcase
    end
  end

  // R9: the Y limit is one of the three duty values
  p_ylim_legal_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (max_y == YW'(7)) || (max_y == YW'(15)) || (max_y == YW'(31)));
  // R10: without the segment option, X spans the whole field
  p_xlim_full_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !seg_opt |-> (max_x == XW'(7)));
endmodule

// File: rtl/lcd_axis_step.sv
module lcd_axis_step #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] lim,
  input  logic         adv,
  output logic         at_top,
  output logic [W-1:0] nxt
);
  always_comb begin
    at_top = (cur >= lim);
    if (!adv)        nxt = cur;
    else if (at_top) nxt = '0;
    else             nxt = cur + W'(1);
  end
endmodule

// File: rtl/lcd_addr_gen.sv
module lcd_addr_gen
  import lcd_addr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [RW-1:0] reg_wdata,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          inc_x,
  input  logic          rmw_mode,
  input  logic [1:0]    duty,
  input  logic          seg_opt,
  output logic [XW-1:0] x_addr,
  output logic [YW-1:0] y_addr
);
  logic          srst_n;
  logic [XW-1:0] max_x;
  logic [YW-1:0] max_y;
  logic [XW-1:0] x_q, x_d, x_step;
  logic [YW-1:0] y_q, y_d, y_step;
  logic          x_top, y_top;
  logic          qual, x_adv, y_adv, addr_en;

  lcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  lcd_addr_limits u_lim (
    .clk(clk), .srst_n(srst_n), .duty(duty), .seg_opt(seg_opt),
    .max_x(max_x), .max_y(max_y)
  );

  assign qual  = acc_valid && (acc_write != rmw_mode);
  assign x_adv = qual && (inc_x || y_top);
  assign y_adv = qual && (!inc_x || x_top);

  lcd_axis_step #(.W(XW)) u_xstep (
    .cur(x_q), .lim(max_x), .adv(x_adv), .at_top(x_top), .nxt(x_step)
  );
  lcd_axis_step #(.W(YW)) u_ystep (
    .cur(y_q), .lim(max_y), .adv(y_adv), .at_top(y_top), .nxt(y_step)
  );

  always_comb begin
    addr_en = reg_wr || qual;
    if (reg_wr) begin
      x_d = reg_wdata[RW-1:YW];
      y_d = reg_wdata[YW-1:0];
    end else begin
      x_d = x_step;
      y_d = y_step;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (addr_en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_addr = x_q;
  assign y_addr = y_q;

  // R1: reset leaves both coordinates at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    !srst_n |=> (x_addr == '0) && (y_addr == '0));
  // R2/R3: a register write is loaded, even with an access in the same cycle
  p_load_wins_r3: assert property (@(posedge clk) disable iff (!srst_n)
    reg_wr |=> ({x_addr, y_addr} == $past(reg_wdata)));
  // R4: no qualifying access and no write means the address holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (!reg_wr && !(acc_valid && (acc_write != rmw_mode))) |=>
      ($stable(x_addr) && $stable(y_addr)));
  // R5: X-fast step below the limit leaves Y alone
  p_xfast_step_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (!reg_wr && qual && inc_x && !x_top) |=>
      (x_addr == $past(x_addr) + XW'(1)) && $stable(y_addr));
  // R7: Y-fast step below the limit leaves X alone
  p_yfast_step_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!reg_wr && qual && !inc_x && !y_top) |=>
      (y_addr == $past(y_addr) + YW'(1)) && $stable(x_addr));
  // R6/R8: a wrap of the fast axis always lands on zero
  p_fast_wrap_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!reg_wr && qual && !inc_x && y_top) |=> (y_addr == '0));
endmodule

// File: tb/lcd_addr_gen_tb.sv
module lcd_addr_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, acc_valid, acc_write, inc_x, rmw_mode, seg_opt;
  logic [7:0] reg_wdata;
  logic [1:0] duty;
  logic [2:0] x_addr;
  logic [4:0] y_addr;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [2:0]  ex;
  logic [4:0]  ey;

  always #5 clk = ~clk;

  lcd_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .inc_x(inc_x),
    .rmw_mode(rmw_mode), .duty(duty), .seg_opt(seg_opt),
    .x_addr(x_addr), .y_addr(y_addr)
  );

  function automatic int lim_y(input logic [1:0] d);
    return (d == 2'b00) ? 7 : (d == 2'b01) ? 15 : 31;
  endfunction

  function automatic int lim_x(input logic [1:0] d, input logic s);
    if (!s || d == 2'b00) return 7;
    return (d == 2'b01) ? 6 : 4;
  endfunction

  task automatic model_step(output string tag);
    int mx, my, nx, ny;
    logic q;
    mx = lim_x(duty, seg_opt);
    my = lim_y(duty);
    nx = ex; ny = ey;
    q = acc_valid && (rmw_mode ? !acc_write : acc_write);
    tag = "R4";
    if (reg_wr) begin
      nx = reg_wdata[7:5]; ny = reg_wdata[4:0];
      tag = q ? "R3" : "R2";
    end else if (q) begin
      if (inc_x) begin
        if (ex >= mx) begin
          nx = 0; ny = (ey >= my) ? 0 : ey + 1;
          tag = (ex > mx || ey > my) ? "R11" : "R6";
        end else begin nx = ex + 1; tag = "R5"; end
      end else begin
        if (ey >= my) begin
          ny = 0; nx = (ex >= mx) ? 0 : ex + 1;
          tag = (ex > mx || ey > my) ? "R11" : (seg_opt ? "R10" : "R8");
        end else begin ny = ey + 1; tag = (duty == 2'b00) ? "R9" : "R7"; end
      end
    end
    ex = 3'(nx); ey = 5'(ny);
  endtask

  task automatic cycle(input logic w, input logic [7:0] wd, input logic av,
                       input logic aw, input logic ix, input logic rm,
                       input logic [1:0] du, input logic so);
    string tag;
    @(negedge clk);
    reg_wr = w; reg_wdata = wd; acc_valid = av; acc_write = aw;
    inc_x = ix; rmw_mode = rm; duty = du; seg_opt = so;
    @(posedge clk);
    model_step(tag);
    #1;
    n_chk++;
    if (x_addr !== ex || y_addr !== ey) begin
      n_bad++;
      $display("FAIL %s: got x=%0d y=%0d expected x=%0d y=%0d", tag, x_addr, y_addr, ex, ey);
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    reg_wr = 0; reg_wdata = 0; acc_valid = 0; acc_write = 0;
    inc_x = 0; rmw_mode = 0; duty = 0; seg_opt = 0;
    ex = 0; ey = 0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (x_addr !== 0 || y_addr !== 0) begin
      n_bad++;
      $display("FAIL R1: got x=%0d y=%0d expected x=0 y=0", x_addr, y_addr);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (x_addr !== 0 || y_addr !== 0) begin
      n_bad++;
      $display("FAIL R1: got x=%0d y=%0d expected x=0 y=0 after release", x_addr, y_addr);
    end

    // R2 load, R5/R6 double carry at 1/8, x-fast
    cycle(1, {3'd7, 5'd7}, 0, 0, 1, 0, 2'b00, 0);
    cycle(0, 0, 1, 1, 1, 0, 2'b00, 0);           // R6: both wrap to 0
    // R8 y-fast double carry at 1/16 with segment option (x max 6)
    cycle(1, {3'd6, 5'd15}, 0, 0, 0, 0, 2'b01, 1);
    cycle(0, 0, 1, 1, 0, 0, 2'b01, 1);           // R8/R10
    // R10 1/32 seg: x max 4
    cycle(1, {3'd4, 5'd3}, 0, 0, 1, 0, 2'b10, 1);
    cycle(0, 0, 1, 1, 1, 0, 2'b10, 1);
    // R11 above-limit load wraps
    cycle(1, {3'd7, 5'd20}, 0, 0, 0, 0, 2'b01, 1);
    cycle(0, 0, 1, 1, 0, 0, 2'b01, 1);
    // R4 rmw: write ignored, read counts
    cycle(0, 0, 1, 1, 0, 1, 2'b10, 0);
    cycle(0, 0, 1, 0, 0, 1, 2'b10, 0);
    // R3 write with concurrent access
    cycle(1, {3'd2, 5'd9}, 1, 1, 1, 0, 2'b10, 0);
    // R9 1/32: Y passes 15
    cycle(1, {3'd0, 5'd15}, 0, 0, 0, 0, 2'b11, 0);
    cycle(0, 0, 1, 1, 0, 0, 2'b11, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cycle(($urandom % 8) == 0, r, ($urandom % 4) != 0, 1'($urandom),
            1'($urandom), ($urandom % 4) == 0, 2'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule